// File: doc/BRIEF.md
# ROM Data-Value Address Profiler

This block walks a read-only program space that a CPU sees at a fixed base address, through a synchronous read port. It builds a reverse lookup that maps each byte value to a CPU address where the ROM holds that value. A later controller that has to write a value V to a register sharing the ROM's data bus can then aim the write at an address where the ROM already drives V, so the two drivers never disagree.

The scan runs in two phases. The first phase walks upward from the lowest address and stops at the first location that holds 0x00. It reports that location as the root address, which is the safe place to write zero. The second phase walks the whole space and records the first address of every byte value. If the ROM never holds 0x00, the block reports that no root exists, leaves the table empty and skips the second phase. Values that never occur stay marked as not found in a per-value flag vector. The table is read through a registered index port.

Top module: `rom_value_profiler`

## Requirements
- R1: After reset, busy, done, root_valid, no_root and rom_rd are 0, found_cnt is 0 and every bit of found_vec is 0.
- R2: A start pulse while idle clears all found flags and begins the root phase. Read addresses rise by one from offset 0. root_addr becomes BASE_ADDR plus the lowest offset whose byte is 0x00, and root_valid is set.
- R3: After the full phase, table entry v (read through tbl_idx = v) holds BASE_ADDR plus the lowest offset whose byte equals v. Later occurrences never replace it.
- R4: found_vec bit v is 1 exactly when value v occurs in the ROM, and found_cnt equals the number of set bits.
- R5: done is high for exactly one cycle, in the first cycle that busy is low after a scan.
- R6: If no byte is 0x00, no_root is set and root_valid stays 0. The full phase is skipped, so found_vec stays all zero. busy lasts 2^ADDR_W + ROM_LAT cycles.
- R7: With a root at offset r, busy lasts (r + 1 + ROM_LAT) + (2^ADDR_W + ROM_LAT) cycles. The read data of each address is used ROM_LAT cycles after it is issued.
- R8: A start pulse while busy is ignored: the scan neither restarts nor changes length.
- R9: rom_rd is 0 whenever busy is 0.
- R10: tbl_addr shows the entry selected by tbl_idx one clock after tbl_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| root_valid | output | 1 | A zero byte was found |
| no_root | output | 1 | No zero byte exists in the ROM |
| root_addr | output | 16 | CPU address of the first zero byte |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | ADDR_W | ROM offset being read |
| rom_data | input | DATA_W | ROM data, ROM_LAT cycles after the address |
| tbl_idx | input | DATA_W | Table read index (byte value) |
| tbl_addr | output | 16 | Recorded CPU address for tbl_idx, registered |
| found_vec | output | 2^DATA_W | Per-value found flags |
| found_cnt | output | DATA_W+1 | Number of distinct values found |

## Verification
The hardest situations to reach are the extremes of the root search: a zero only in the very last location, no zero at all, and a zero at offset 0. In these cases the phase switch happens right at the end or the start of the address sweep, or the second phase never runs. The bench reaches them with a small ADDR_W and a ROM model that computes each byte from the address under a selectable pattern. It also uses patterns that fill every value, every fourth value, or only two values, so both a full table and a sparse one are covered. A stray start pulse injected mid-scan shows whether restart protection holds, because the busy length would then change.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROOT = 2'd1,
      PH_FULL = 2'd2
   } rvp_phase_e;

   // One in-flight ROM read: valid, phase it belongs to, offset read
   typedef struct packed {
      logic        vld;
      logic        full;
      logic [15:0] off;
   } rvp_tag_t;

   localparam int unsigned RVP_CPU_AW = 16;
endpackage

// File: rtl/rvp_addr_gen.sv
module rvp_addr_gen
   import rvp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 15,
   parameter int unsigned ROM_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              phase_full,
   input  logic              halt,
   output logic              rom_rd,
   output logic [ADDR_W-1:0] rom_addr,
   output rvp_tag_t          ret_tag,
   output logic              ret_last
);
   localparam logic [ADDR_W-1:0] LAST_OFF = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] ptr_q;
   logic              active_q;
   logic              full_q;
   rvp_tag_t          issue_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         active_q <= 1'b0;
         full_q   <= 1'b0;
      end else if (restart) begin
         ptr_q    <= '0;
         active_q <= 1'b1;
         full_q   <= phase_full;
      end else if (halt) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         ptr_q <= ptr_q + 1'b1;
         if (ptr_q == LAST_OFF) active_q <= 1'b0;
      end
   end

   assign rom_rd   = active_q;
   assign rom_addr = ptr_q;

   always_comb begin
      issue_tag      = '0;
      issue_tag.vld  = active_q;
      issue_tag.full = full_q;
      issue_tag.off  = 16'(ptr_q);
   end

   // Delay line matching the ROM read latency
   generate
      if (ROM_LAT == 1) begin : g_lat_one
         rvp_tag_t tag_q;
         always_ff @(posedge clk) begin
            if (!rst_n) tag_q <= '0;
            else        tag_q <= issue_tag;
         end
         assign ret_tag = tag_q;
      end else begin : g_lat_multi
         rvp_tag_t tag_q [ROM_LAT];
         for (genvar s = 0; s < ROM_LAT; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)      tag_q[s] <= '0;
               else if (s == 0) tag_q[s] <= issue_tag;
               else             tag_q[s] <= tag_q[s-1];
            end
         end
         assign ret_tag = tag_q[ROM_LAT-1];
      end
   endgenerate

   assign ret_last = (ret_tag.off[ADDR_W-1:0] == LAST_OFF);
endmodule

// File: rtl/rvp_table.sv
module rvp_table #(
   parameter int unsigned DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr_req,
   input  logic [DATA_W-1:0]    wr_val,
   input  logic [15:0]          wr_addr,
   input  logic [DATA_W-1:0]    rd_idx,
   output logic [15:0]          rd_addr,
   output logic [(1<<DATA_W)-1:0] found_vec,
   output logic [DATA_W:0]      found_cnt
);
   localparam int unsigned VALS = 1 << DATA_W;

   logic [15:0]     mem_q [VALS];
   logic [VALS-1:0] found_q;
   logic [DATA_W:0] cnt_q;
   logic            take;

   assign take = wr_req && !found_q[wr_val];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         found_q <= '0;
         cnt_q   <= '0;
      end else if (clr) begin
         found_q <= '0;
         cnt_q   <= '0;
      end else if (take) begin
         found_q[wr_val] <= 1'b1;
         cnt_q           <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (take && !clr) mem_q[wr_val] <= wr_addr;
      rd_addr <= mem_q[rd_idx];
   end

   assign found_vec = found_q;
   assign found_cnt = cnt_q;
endmodule

// File: rtl/rvp_ctrl.sv
module rvp_ctrl
   import rvp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned DATA_W    = 8,
   parameter logic [15:0] BASE_ADDR = 16'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  rvp_tag_t          ret_tag,
   input  logic              ret_last,
   input  logic [DATA_W-1:0] ret_data,
   output logic              restart,
   output logic              phase_full,
   output logic              halt,
   output logic              tbl_clr,
   output logic              tbl_wr,
   output logic [15:0]       cpu_addr,
   output logic              busy,
   output logic              done,
   output logic              root_valid,
   output logic              no_root,
   output logic [15:0]       root_addr
);
   rvp_phase_e state_q;
   logic       done_q;
   logic       rv_q;
   logic       nr_q;
   logic [15:0] ra_q;
   logic       ret_root;
   logic       ret_full;
   logic       zero_hit;

   assign ret_root = ret_tag.vld && !ret_tag.full && (state_q == PH_ROOT);
   assign ret_full = ret_tag.vld &&  ret_tag.full && (state_q == PH_FULL);
   assign zero_hit = ret_root && (ret_data == '0);
   assign cpu_addr = BASE_ADDR | ret_tag.off;

   always_comb begin
      restart    = 1'b0;
      phase_full = 1'b0;
      halt       = 1'b0;
      tbl_clr    = 1'b0;
      if (state_q == PH_IDLE && start) begin
         restart = 1'b1;
         tbl_clr = 1'b1;
      end else if (zero_hit) begin
         restart    = 1'b1;
         phase_full = 1'b1;
      end else if (ret_root && ret_last) begin
         halt = 1'b1;
      end
   end

   assign tbl_wr = ret_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         done_q  <= 1'b0;
         rv_q    <= 1'b0;
         nr_q    <= 1'b0;
         ra_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            PH_IDLE: if (start) begin
               state_q <= PH_ROOT;
               rv_q    <= 1'b0;
               nr_q    <= 1'b0;
               ra_q    <= '0;
            end
            PH_ROOT: if (zero_hit) begin
               state_q <= PH_FULL;
               rv_q    <= 1'b1;
               ra_q    <= cpu_addr;
            end else if (ret_root && ret_last) begin
               state_q <= PH_IDLE;
               nr_q    <= 1'b1;
               done_q  <= 1'b1;
            end
            PH_FULL: if (ret_full && ret_last) begin
               state_q <= PH_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != PH_IDLE);
   assign done       = done_q;
   assign root_valid = rv_q;
   assign no_root    = nr_q;
   assign root_addr  = ra_q;
endmodule

// File: rtl/rom_value_profiler.sv
module rom_value_profiler
   import rvp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ROM_LAT   = 1,
   parameter logic [15:0] BASE_ADDR = 16'h8000,
   localparam int unsigned VALS     = 1 << DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              root_valid,
   output logic              no_root,
   output logic [15:0]       root_addr,
   output logic              rom_rd,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data,
   input  logic [DATA_W-1:0] tbl_idx,
   output logic [15:0]       tbl_addr,
   output logic [VALS-1:0]   found_vec,
   output logic [DATA_W:0]   found_cnt
);
   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 2 || ADDR_W > RVP_CPU_AW)
         begin : g_bad_aw  $error("ADDR_W out of range"); end
      if (DATA_W < 1 || DATA_W > 8)
         begin : g_bad_dw  $error("DATA_W out of range"); end
      if (ROM_LAT < 1 || ROM_LAT > 8)
         begin : g_bad_lat $error("ROM_LAT out of range"); end
      if (ADDR_W < RVP_CPU_AW && (BASE_ADDR & ((16'd1 << ADDR_W) - 16'd1)) != 16'd0)
         begin : g_bad_base $error("BASE_ADDR not aligned to the ROM size"); end
   endgenerate

   logic     restart, phase_full, halt, tbl_clr, tbl_wr;
   logic [15:0] cpu_addr;
   rvp_tag_t ret_tag;
   logic     ret_last;

   rvp_addr_gen #(.ADDR_W(ADDR_W), .ROM_LAT(ROM_LAT)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .phase_full (phase_full),
      .halt       (halt),
      .rom_rd     (rom_rd),
      .rom_addr   (rom_addr),
      .ret_tag    (ret_tag),
      .ret_last   (ret_last)
   );

   rvp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .ret_tag    (ret_tag),
      .ret_last   (ret_last),
      .ret_data   (rom_data),
      .restart    (restart),
      .phase_full (phase_full),
      .halt       (halt),
      .tbl_clr    (tbl_clr),
      .tbl_wr     (tbl_wr),
      .cpu_addr   (cpu_addr),
      .busy       (busy),
      .done       (done),
      .root_valid (root_valid),
      .no_root    (no_root),
      .root_addr  (root_addr)
   );

   rvp_table #(.DATA_W(DATA_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tbl_clr),
      .wr_req    (tbl_wr),
      .wr_val    (rom_data),
      .wr_addr   (cpu_addr),
      .rd_idx    (tbl_idx),
      .rd_addr   (tbl_addr),
      .found_vec (found_vec),
      .found_cnt (found_cnt)
   );
endmodule

// File: rtl/rvp_checker.sv
module rvp_checker #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    busy,
   input logic                    done,
   input logic                    root_valid,
   input logic                    no_root,
   input logic                    rom_rd,
   input logic [ADDR_W-1:0]       rom_addr,
   input logic [(1<<DATA_W)-1:0]  found_vec,
   input logic [DATA_W:0]         found_cnt
);
   AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rom_rd); // R9
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && $past(rom_rd)) |->
         (rom_addr == ADDR_W'($past(rom_addr) + 1'b1)) || (rom_addr == '0)); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R5
   AST_ROOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(root_valid && no_root)); // R6
   AST_CNT_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      found_cnt == ($countones(found_vec))); // R4
   AST_NOROOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      no_root |-> (found_vec == '0)); // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && start && root_valid) |=> root_valid); // R8
endmodule

bind rom_value_profiler rvp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rvp_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .root_valid (root_valid),
   .no_root    (no_root),
   .rom_rd     (rom_rd),
   .rom_addr   (rom_addr),
   .found_vec  (found_vec),
   .found_cnt  (found_cnt)
);

// File: tb/test_rom_value_profiler.sv
module test_rom_value_profiler;
   localparam int AW   = 10;
   localparam int NADR = 1 << AW;
   localparam int LAT  = 1;
   localparam logic [15:0] BASE = 16'h8000;

   typedef struct packed {
      logic [1:0]  pat;
      logic        exp_nr;
      logic [10:0] root_off;
      logic [8:0]  cnt;
   } vec_t;

   // pattern, no-root expected, root offset, distinct values
   localparam vec_t VECS [4] = '{
      '{2'd0, 1'b0, 11'd90,   9'd256},
      '{2'd1, 1'b0, 11'd0,    9'd64},
      '{2'd2, 1'b1, 11'd0,    9'd0},
      '{2'd3, 1'b0, 11'd1023, 9'd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, root_valid, no_root, rom_rd;
   logic [15:0] root_addr, tbl_addr;
   logic [AW-1:0] rom_addr;
   logic [7:0] rom_data = 8'h00;
   logic [7:0] tbl_idx = 8'h00;
   logic [255:0] found_vec;
   logic [8:0] found_cnt;
   int pat = 0;
   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   function automatic int rom_byte(int p, int a);
      case (p)
         0:       return (a ^ 'h5A) & 'hFF;
         1:       return (a & 63) << 2;
         2:       return (a & 255) | 1;
         default: return (a == NADR - 1) ? 0 : 'hA5;
      endcase
   endfunction

   always_ff @(posedge clk) if (rom_rd) rom_data <= 8'(rom_byte(pat, int'(rom_addr)));

   rom_value_profiler #(.ADDR_W(AW), .DATA_W(8), .ROM_LAT(LAT), .BASE_ADDR(BASE)) i_rom_value_profiler (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .root_valid(root_valid), .no_root(no_root), .root_addr(root_addr),
      .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
      .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .found_vec(found_vec), .found_cnt(found_cnt)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_scan(input vec_t v, input bit inject);
      int cyc = 0;
      int exp_cyc;
      int first [256];
      int cnt = 0;
      pat = int'(v.pat);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (busy) begin
         cyc++;
         if (inject && cyc == 5) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R5", "done when busy falls", int'(done), 1);
      if (v.exp_nr) begin
         exp_cyc = NADR + LAT;
         chk(cyc == exp_cyc, "R6", "busy cycles without root", cyc, exp_cyc);
         chk(no_root && !root_valid, "R6", "no_root flag", int'(no_root), 1);
      end else begin
         exp_cyc = int'(v.root_off) + 1 + LAT + NADR + LAT;
         chk(cyc == exp_cyc, inject ? "R8" : "R7", "busy cycles", cyc, exp_cyc);
         chk(root_valid && !no_root, "R2", "root_valid", int'(root_valid), 1);
         chk(root_addr == (BASE | 16'(v.root_off)), "R2", "root_addr",
             int'(root_addr), int'(BASE | 16'(v.root_off)));
      end
      @(negedge clk);
      chk(done == 1'b0, "R5", "done width", int'(done), 0);
      // expected first occurrences, computed from the ROM pattern
      for (int i = 0; i < 256; i++) first[i] = -1;
      if (!v.exp_nr)
         for (int a = 0; a < NADR; a++)
            if (first[rom_byte(pat, a)] < 0) begin
               first[rom_byte(pat, a)] = a;
               cnt++;
            end
      chk(int'(found_cnt) == cnt, "R4", "found_cnt", int'(found_cnt), cnt);
      chk(cnt == int'(v.cnt), "R4", "vector count", cnt, int'(v.cnt));
      for (int i = 0; i < 256; i++) begin
         tbl_idx = 8'(i);
         @(negedge clk);
         chk(found_vec[i] == (first[i] >= 0), "R4", $sformatf("found_vec[%0d]", i),
             int'(found_vec[i]), int'(first[i] >= 0));
         if (first[i] >= 0)
            chk(int'(tbl_addr) == (int'(BASE) | first[i]), "R3", $sformatf("entry %0d (R10 read)", i),
                int'(tbl_addr), int'(BASE) | first[i]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !rom_rd, "R1", "idle outputs", int'(busy), 0);
      chk(!root_valid && !no_root, "R1", "root flags", int'(root_valid), 0);
      chk(found_cnt == 0 && found_vec == '0, "R1", "found state", int'(found_cnt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rom_rd, "R9", "no reads while idle", int'(rom_rd), 0);
      for (int k = 0; k < 4; k++) run_scan(VECS[k], 1'b0);
      // R8: stray start mid-scan must not restart
      run_scan(VECS[0], 1'b1);
      // no-root after a full run clears old flags (R2, R6)
      run_scan(VECS[2], 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule